// File: doc/BRIEF.md
# Quad Compare Timer

The block provides four independent up-counters that share one system clock. Each counter advances once for every `PRESCALE` system clocks while it is running, and each has its own prescaler. A counter compares its value with a programmable match value. When the counter reaches that value, the channel sets two sticky flags. The channel then either stops, keeps counting past the match, or jumps back to a programmable reload value, depending on its configuration.

A single run register, held in channel 0, starts and stops the channels. It has one bit for each channel. One interrupt line combines every flag whose enable bit is set. A pending vector, also held in channel 0, shows which channels are raising that interrupt.

Software uses a simple synchronous register port. The address is `{channel, register}`, with a register index of 3 bits. Writes take effect at the clock edge on which `bus_wr` is high. Read data is registered and appears one clock after the address.

Top module: `quad_cmp_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq` is 0 and `active` is 0.
- R2: Run bit n (register 6 of channel 0) starts and stops only channel n. The counters of stopped channels do not move.
- R3: A running counter advances by one every `PRESCALE` clocks. The first step comes `PRESCALE` clocks after the run bit is set. The prescaler restarts from zero each time the run bit rises, so a partial prescale count is discarded.
- R4: When a counter step lands on the match value (register 2), bit 0 of the status register (4) is set, and so is bit 0 of the compare status register (5).
- R5: If config bit 0 (register 3) is set, a match clears the channel's run bit. The counter then holds the match value.
- R6: With config bits 1:0 = 00, a match does not interrupt counting. The counter carries on upward past the match value.
- R7: If config bit 1 is set, a match loads the counter from the reload register (0) instead of the match value.
- R8: Writing 0 to bit 0 of register 4 or register 5 clears that flag, and writing 1 leaves it unchanged. Bit 1 of each of these registers is that flag's interrupt enable. Flags and enables of one channel never change another channel.
- R9: `irq` is high one clock after any channel has a flag set together with its enable. Bit n of register 7 of channel 0 shows this condition for channel n.
- R10: `active[n]` equals run bit n.
- R11: Register 1 returns the live counter and can be written to any value. Register 2 takes an absolute match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | {channel, 3-bit register index} |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data, one clock after address |
| irq | output | 1 | Combined registered interrupt |
| active | output | NCH | Per-channel running indication |

## Verification
The bench stops counters after an exact number of clocks and reads the result. A prescaler that is off by one, or that resumes a partial count after a restart, leaves a different value. One-shot, free-running and reload channels are each run through a match. A wrong stop rule leaves the counter past the match or the run bit still set. A wrong reload rule gives a count that is not the reload value plus the remaining steps. Flag clearing is tested with both 1 and 0 written. A flag that clears on 1 or leaks into another channel changes the status reads or the pending vector. A flag without its enable must keep `irq` low.

// File: rtl/qct_pkg.sv
package qct_pkg;
  typedef enum logic [2:0] {
    REG_LOAD  = 3'd0,
    REG_COUNT = 3'd1,
    REG_MATCH = 3'd2,
    REG_CFG   = 3'd3,
    REG_STAT  = 3'd4,
    REG_CSTAT = 3'd5,
    REG_RUN   = 3'd6,
    REG_PEND  = 3'd7
  } qct_reg_e;

  localparam int CFG_ONESHOT = 0;
  localparam int CFG_RELOAD  = 1;
  localparam int FLG_BIT     = 0;
  localparam int FLG_IE      = 1;
endpackage

// File: rtl/qct_prescaler.sv
module qct_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  assign tick = run && (div_q == LAST);

  // held at zero while stopped, so each start begins a fresh prescale period
  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/qct_channel.sv
module qct_channel
  import qct_pkg::*;
#(
  parameter int W        = 16,
  parameter int PRESCALE = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         wr,
  input  qct_reg_e     wsel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] load,
  output logic [W-1:0] match,
  output logic [1:0]   cfg,
  output logic [1:0]   stat,
  output logic [1:0]   cstat,
  output logic         hit,
  output logic         stop,
  output logic         pend
);
  logic         tick;
  logic [W-1:0] nxt;

  qct_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  assign nxt  = cnt + 1'b1;
  assign hit  = tick && (nxt == match);
  assign stop = hit && cfg[CFG_ONESHOT];
  assign pend = (stat[FLG_BIT] && stat[FLG_IE]) || (cstat[FLG_BIT] && cstat[FLG_IE]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      load  <= '0;
      match <= '0;
      cfg   <= '0;
      stat  <= '0;
      cstat <= '0;
    end else begin
      if (wr && wsel == REG_LOAD)  load  <= wdata;
      if (wr && wsel == REG_MATCH) match <= wdata;
      if (wr && wsel == REG_CFG)   cfg   <= wdata[1:0];

      if (wr && wsel == REG_COUNT) cnt <= wdata;
      else if (tick) cnt <= (hit && cfg[CFG_RELOAD]) ? load : nxt;

      // a match in the same clock as a clearing write keeps the flag set
      if (wr && wsel == REG_STAT) begin
        stat[FLG_IE] <= wdata[FLG_IE];
        if (!wdata[FLG_BIT]) stat[FLG_BIT] <= 1'b0;
      end
      if (hit) stat[FLG_BIT] <= 1'b1;

      if (wr && wsel == REG_CSTAT) begin
        cstat[FLG_IE] <= wdata[FLG_IE];
        if (!wdata[FLG_BIT]) cstat[FLG_BIT] <= 1'b0;
      end
      if (hit) cstat[FLG_BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/quad_cmp_timer.sv
module quad_cmp_timer
  import qct_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int W        = 16,
  parameter int PRESCALE = 128,
  localparam int CH_AW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W  = CH_AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq,
  output logic [NCH-1:0]    active
);
  logic [CH_AW-1:0]        ch_sel;
  qct_reg_e                reg_sel;
  logic [NCH-1:0]          run_q;
  logic                    run_wr;
  logic [NCH-1:0]          ch_wr, cnt_wr, hit, stop, pend;
  logic [NCH-1:0][W-1:0]   cnt, load, match;
  logic [NCH-1:0][1:0]     cfg, stat, cstat;

  assign ch_sel  = bus_addr[ADDR_W-1:3];
  assign reg_sel = qct_reg_e'(bus_addr[2:0]);
  assign run_wr  = bus_wr && (ch_sel == '0) && (reg_sel == REG_RUN);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ch_wr[n]  = bus_wr && (ch_sel == CH_AW'(n));
    assign cnt_wr[n] = ch_wr[n] && (reg_sel == REG_COUNT);

    qct_channel #(.W(W), .PRESCALE(PRESCALE)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .run  (run_q[n]),
      .wr   (ch_wr[n]),
      .wsel (reg_sel),
      .wdata(bus_wdata),
      .cnt  (cnt[n]),
      .load (load[n]),
      .match(match[n]),
      .cfg  (cfg[n]),
      .stat (stat[n]),
      .cstat(cstat[n]),
      .hit  (hit[n]),
      .stop (stop[n]),
      .pend (pend[n])
    );
  end

  // software write to the run register wins over a same-clock one-shot stop
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (run_wr) run_q <= bus_wdata[NCH-1:0];
    else run_q <= run_q & ~stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
      active    <= '0;
    end else begin
      irq    <= |pend;
      active <= run_wr ? bus_wdata[NCH-1:0] : (run_q & ~stop);
      unique case (reg_sel)
        REG_LOAD:  bus_rdata <= load[ch_sel];
        REG_COUNT: bus_rdata <= cnt[ch_sel];
        REG_MATCH: bus_rdata <= match[ch_sel];
        REG_CFG:   bus_rdata <= W'(cfg[ch_sel]);
        REG_STAT:  bus_rdata <= W'(stat[ch_sel]);
        REG_CSTAT: bus_rdata <= W'(cstat[ch_sel]);
        REG_RUN:   bus_rdata <= (ch_sel == '0) ? W'(run_q) : '0;
        REG_PEND:  bus_rdata <= (ch_sel == '0) ? W'(pend) : '0;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/qct_checker.sv
module qct_checker #(
  parameter int NCH = 4,
  parameter int W   = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  irq,
  input logic [NCH-1:0]        active,
  input logic [NCH-1:0]        run_q,
  input logic                  run_wr,
  input logic [NCH-1:0]        cnt_wr,
  input logic [NCH-1:0]        hit,
  input logic [NCH-1:0]        stop,
  input logic [NCH-1:0]        pend,
  input logic [NCH-1:0][W-1:0] cnt,
  input logic [NCH-1:0][1:0]   stat
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq && active == '0));

  a_r9_irq_tracks_pending: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|pend));

  a_r10_active_is_run: assert property (@(posedge clk) disable iff (rst)
    active == run_q);

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
      (stop[n] && !run_wr) |=> !run_q[n]);

    a_r2_idle_counter_holds: assert property (@(posedge clk) disable iff (rst)
      (!run_q[n] && !cnt_wr[n]) |=> $stable(cnt[n]));

    a_r4_flag_needs_match: assert property (@(posedge clk) disable iff (rst)
      $rose(stat[n][0]) |-> $past(hit[n]));
  end
endmodule

bind quad_cmp_timer qct_checker #(.NCH(NCH), .W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .irq   (irq),
  .active(active),
  .run_q (run_q),
  .run_wr(run_wr),
  .cnt_wr(cnt_wr),
  .hit   (hit),
  .stop  (stop),
  .pend  (pend),
  .cnt   (cnt),
  .stat  (stat)
);

// File: tb/quad_cmp_timer_tb.sv
`timescale 1ns/1ps
module quad_cmp_timer_tb;
  localparam int NCH = 4;
  localparam int W   = 16;
  localparam int PRE = 4;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          irq;
  logic [NCH-1:0] active;

  quad_cmp_timer #(.NCH(NCH), .W(W), .PRESCALE(PRE)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .active(active)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit          pins;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  bit    req = 1'b0;
  bit    req_d = 1'b0;
  int    checks = 0;
  int    errors = 0;

  always @(posedge clk) req_d <= req;

  // monitor: compares one result per request, one clock after it was issued
  always @(negedge clk) begin
    if (req_d) begin
      item_t it;
      logic [15:0] act;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: result with no expected item");
      end else begin
        it  = q.pop_front();
        act = it.pins ? {11'd0, irq, active} : bus_rdata;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%h expected 0x%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int ch, input int r, input logic [15:0] d);
    bus_addr  = AW'((ch << 3) | r);
    bus_wdata = d;
    bus_wr    = 1'b1;
    req       = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input int ch, input int r, input logic [15:0] e, input string tag);
    bus_addr = AW'((ch << 3) | r);
    q.push_back('{1'b0, e, tag});
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_pins(input logic [15:0] e, input string tag);
    q.push_back('{1'b1, e, tag});
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk_rd(0, 1, 16'h0, "R1 count");
    chk_rd(2, 2, 16'h0, "R1 match");
    chk_rd(0, 6, 16'h0, "R1 run");
    chk_rd(3, 4, 16'h0, "R1 stat");
    chk_pins(16'h0, "R1 pins");

    // R11: live counter and absolute match writes
    wr(1, 1, 16'h1234);
    chk_rd(1, 1, 16'h1234, "R11 count write");
    wr(1, 2, 16'hBEEF);
    chk_rd(1, 2, 16'hBEEF, "R11 match write");
    wr(1, 1, 16'h0);

    // R3/R2: channel 0 alone for 40 clocks -> 10 steps
    wr(0, 2, 16'hFFFF);
    wr(0, 6, 16'h1);
    chk_pins(16'h01, "R10 active ch0");
    repeat (38) @(negedge clk);
    wr(0, 6, 16'h0);
    chk_rd(0, 1, 16'd10, "R3 divide");
    chk_rd(1, 1, 16'd0, "R2 ch1 idle");
    chk_rd(3, 1, 16'd0, "R2 ch3 idle");

    // R3: restart discards partial prescale
    wr(0, 1, 16'h0);
    wr(0, 6, 16'h1);
    repeat (5) @(negedge clk);
    wr(0, 6, 16'h0);
    chk_rd(0, 1, 16'd1, "R3 six clocks");
    wr(0, 6, 16'h1);
    repeat (1) @(negedge clk);
    wr(0, 6, 16'h0);
    chk_rd(0, 1, 16'd1, "R3 prescaler restart");

    // R4/R5: one-shot on channel 2, both enables on
    wr(2, 2, 16'd5);
    wr(2, 3, 16'h1);
    wr(2, 4, 16'h2);
    wr(2, 5, 16'h2);
    wr(0, 6, 16'h4);
    repeat (30) @(negedge clk);
    chk_rd(2, 1, 16'd5, "R5 holds match");
    chk_rd(0, 6, 16'h0, "R5 run cleared");
    chk_rd(2, 4, 16'h3, "R4 stat flag");
    chk_rd(2, 5, 16'h3, "R4 cstat flag");
    chk_pins(16'h10, "R9 irq set, R10 inactive");
    chk_rd(0, 7, 16'h4, "R9 pending ch2");

    // R8: clear semantics and independence
    wr(2, 4, 16'h3);
    chk_rd(2, 4, 16'h3, "R8 write 1 keeps");
    wr(2, 4, 16'h2);
    chk_rd(2, 4, 16'h2, "R8 write 0 clears");
    chk_rd(0, 4, 16'h0, "R8 ch0 unaffected");
    chk_pins(16'h10, "R8 cstat still drives irq");
    wr(2, 5, 16'h2);
    chk_pins(16'h00, "R8 irq low after clears");
    chk_rd(0, 7, 16'h0, "R9 pending clear");

    // R6: free-running past match, enables off
    wr(3, 2, 16'd3);
    wr(0, 6, 16'h8);
    repeat (39) @(negedge clk);
    wr(0, 6, 16'h0);
    chk_rd(3, 1, 16'd10, "R6 counts past match");
    chk_rd(3, 4, 16'h1, "R4 ch3 stat");
    chk_rd(3, 5, 16'h1, "R4 ch3 cstat");
    chk_pins(16'h00, "R9 flag without enable");

    // R7: reload on match
    wr(1, 0, 16'h0100);
    wr(1, 2, 16'd2);
    wr(1, 3, 16'h2);
    wr(0, 6, 16'h2);
    repeat (39) @(negedge clk);
    wr(0, 6, 16'h0);
    chk_rd(1, 1, 16'h0108, "R7 reload");
    chk_rd(1, 4, 16'h1, "R7 flag");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule